// File: doc/BRIEF.md
# Bit-Plane Pass Sequencer with Symbol Queues

The block walks the bit-planes of one code-block of coefficient magnitudes, from the most significant non-zero plane down to plane 0, and runs the embedded coding passes on each plane. The top plane gets the cleanup pass only. Every lower plane gets significance propagation, then magnitude refinement, then cleanup. Coefficients come from an external code-block RAM with a one-cycle synchronous read. The RAM is read in stripes four rows tall, column by column, top to bottom within each column. Significance and visited flags for each coefficient are held inside the block.

Each coded bit yields a symbol: a 5-bit context label and a decision bit. The symbol is pushed into the queue of the pass that produced it. A drain controller empties one queue completely before it moves to the next, so the serial output keeps the sequential pass order even though the passes produce symbols in bursts. The output goes to a downstream arithmetic coder over a valid/ready handshake. When every symbol has left, the block raises a one-cycle flush request.

A code-block starts with a one-cycle `start_i` pulse while the block is idle.

Top module: `bitplane_pass_sequencer`

## Requirements
- R1: After reset, `sym_valid_o` and `flush_o` are low.
- R2: The first plane coded is the highest bit position set in any magnitude of the block. That plane gets only the cleanup pass, and every coefficient is coded in it.
- R3: Each lower plane, down to plane 0, is coded as significance propagation, then refinement, then cleanup. Each coefficient is coded exactly once per plane, so a block emits COLS*ROWS*(top+1) symbols.
- R4: Significance propagation codes a coefficient that is insignificant and has at least one significant 4-neighbour (up, down, left or right). A 1 bit makes that coefficient significant. Refinement codes coefficients that were significant before the current plane. Cleanup codes every coefficient not yet coded in the plane, and a 1 bit makes it significant.
- R5: Context label fields: bits [4:3] hold the pass code (0 significance propagation, 1 refinement, 2 cleanup). Bits [2:0] hold the number of significant 4-neighbours at coding time. The decision bit is the coefficient's magnitude bit on the current plane.
- R6: A symbol transfers only in a cycle where valid and ready are both high. While valid is high and ready is low, the symbol is held unchanged.
- R7: Under any ready pattern, no symbol is lost or duplicated. The producer stalls when the queue it targets is full.
- R8: `flush_o` pulses for exactly one cycle, after the last symbol has transferred. A block whose magnitudes are all zero gives no symbols and only the flush.
- R9: Within a pass, coefficients are visited stripe by stripe, each stripe column by column and each column top to bottom. `mem_addr_o` carries the raster address row*COLS+col.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a code-block (accepted when idle) |
| mem_addr_o | output | ADDR_W | Code-block RAM read address |
| mem_rdata_i | input | MAG_W | Magnitude read, one cycle after address |
| sym_valid_o | output | 1 | Symbol available |
| sym_ready_i | input | 1 | Coder accepts symbol |
| sym_ctx_o | output | 5 | Context label |
| sym_bit_o | output | 1 | Decision bit |
| flush_o | output | 1 | One-cycle flush request at block end |

## Verification
The bench targets an all-zero block, a single isolated coefficient whose neighbours are picked up by significance propagation, a block whose top plane is 0 and so gets a single pass, and dense blocks driven under heavy backpressure. A producer that did not stall on a full queue would drop symbols, and the count and order checks would report it. A controller that interleaved queues would put refinement symbols ahead of significance symbols. A wrong neighbour rule or a wrong scan order would show up as a wrong context label or a wrong decision bit at some position. A flush raised too early, or held for more than one cycle, is caught against the number of symbols already received.

// File: rtl/bpps_pkg.sv
package bpps_pkg;
  typedef enum logic [1:0] {
    PASS_SP = 2'd0,
    PASS_MR = 2'd1,
    PASS_CU = 2'd2
  } pass_e;

  localparam int CTX_W = 5;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             dbit;
  } sym_t;
endpackage

// File: rtl/bpps_fifo.sv
module bpps_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o && !pop_i));
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));
endmodule

// File: rtl/bpps_pass_gen.sv
module bpps_pass_gen
  import bpps_pkg::*;
#(
  parameter int COLS    = 4,
  parameter int STRIPES = 2,
  parameter int MAG_W   = 4,
  localparam int ADDR_W = $clog2(COLS * 4 * STRIPES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [MAG_W-1:0]  rdata_i,
  input  logic [2:0]        closed_i,
  input  logic [2:0]        full_i,
  output logic [2:0]        push_o,
  output sym_t              sym_o,
  output logic [2:0]        close_o,
  output logic              begin_o,
  output logic              fin_o,
  input  logic              flush_i
);
  localparam int ROWS    = 4 * STRIPES;
  localparam int N       = COLS * ROWS;
  localparam int COL_W   = $clog2(COLS);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int PLANE_W = (MAG_W > 1) ? $clog2(MAG_W) : 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SRD, ST_SEV, ST_WAIT, ST_RD, ST_EV, ST_FIN
  } state_e;

  state_e              state_q;
  pass_e               pass_q;
  logic [ADDR_W-1:0]   k_q;
  logic [PLANE_W-1:0]  plane_q;
  logic [MAG_W-1:0]    acc_q, acc_n;
  logic [N-1:0]        sig_q, vis_q;

  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] cur;
  logic [2:0]        nb;
  logic              last, dbit, emit, blocked, step;

  function automatic logic [PLANE_W-1:0] top_bit(input logic [MAG_W-1:0] v);
    top_bit = '0;
    for (int i = 0; i < MAG_W; i++) if (v[i]) top_bit = PLANE_W'(i);
  endfunction

  // stripe-major, column-major inside stripe, 4 rows per column
  assign col    = k_q[COL_W+1:2];
  assign row    = ROW_W'({k_q >> (COL_W + 2), k_q[1:0]});
  assign cur    = {row, col};
  assign addr_o = cur;
  assign last   = (k_q == ADDR_W'(N - 1));
  assign acc_n  = acc_q | rdata_i;
  assign dbit   = rdata_i[plane_q];

  always_comb begin
    nb = '0;
    if (row != '0 && sig_q[cur - ADDR_W'(COLS)])              nb = nb + 3'd1;
    if (row != ROW_W'(ROWS - 1) && sig_q[cur + ADDR_W'(COLS)]) nb = nb + 3'd1;
    if (col != '0 && sig_q[cur - ADDR_W'(1)])                  nb = nb + 3'd1;
    if (col != COL_W'(COLS - 1) && sig_q[cur + ADDR_W'(1)])    nb = nb + 3'd1;
  end

  always_comb begin
    case (pass_q)
      PASS_SP: emit = !sig_q[cur] && (nb != '0);
      PASS_MR: emit = sig_q[cur] && !vis_q[cur];
      default: emit = !sig_q[cur] && !vis_q[cur];
    endcase
  end

  assign blocked = emit && full_i[pass_q];
  assign step    = (state_q == ST_EV) && !blocked;
  assign push_o  = (step && emit) ? (3'b001 << pass_q) : 3'b000;
  assign close_o = (step && last) ? (3'b001 << pass_q) : 3'b000;
  assign sym_o   = '{ctx: {pass_q, nb}, dbit: dbit};
  assign begin_o = (state_q == ST_IDLE) && start_i;
  assign fin_o   = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= PASS_CU;
      k_q     <= '0;
      plane_q <= '0;
      acc_q   <= '0;
      sig_q   <= '0;
      vis_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          k_q     <= '0;
          acc_q   <= '0;
          sig_q   <= '0;
          vis_q   <= '0;
          state_q <= ST_SRD;
        end
        ST_SRD: state_q <= ST_SEV;
        ST_SEV: begin
          acc_q <= acc_n;
          if (last) begin
            k_q <= '0;
            if (acc_n == '0) state_q <= ST_FIN;
            else begin
              plane_q <= top_bit(acc_n);
              pass_q  <= PASS_CU;
              state_q <= ST_WAIT;
            end
          end else begin
            k_q     <= k_q + 1'b1;
            state_q <= ST_SRD;
          end
        end
        // a pass may start only once its queue has been drained and released
        ST_WAIT: if (!closed_i[pass_q]) begin
          k_q     <= '0;
          state_q <= ST_RD;
        end
        ST_RD: state_q <= ST_EV;
        ST_EV: if (!blocked) begin
          if (pass_q == PASS_SP && emit) begin
            vis_q[cur] <= 1'b1;
            if (dbit) sig_q[cur] <= 1'b1;
          end
          if (pass_q == PASS_CU) begin
            vis_q[cur] <= 1'b0;
            if (emit && dbit) sig_q[cur] <= 1'b1;
          end
          if (last) begin
            state_q <= ST_WAIT;
            case (pass_q)
              PASS_SP: pass_q <= PASS_MR;
              PASS_MR: pass_q <= PASS_CU;
              default: begin
                if (plane_q == '0) state_q <= ST_FIN;
                else begin
                  plane_q <= plane_q - 1'b1;
                  pass_q  <= PASS_SP;
                end
              end
            endcase
          end else begin
            k_q     <= k_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        ST_FIN: if (flush_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_close_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(close_o));
  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EV && blocked) |=> (state_q == ST_EV && $stable(k_q)));
endmodule

// File: rtl/bpps_drain.sv
module bpps_drain
  import bpps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       begin_i,
  input  sym_t       head_sp_i,
  input  sym_t       head_mr_i,
  input  sym_t       head_cu_i,
  input  logic [2:0] empty_i,
  input  logic [2:0] close_i,
  input  logic       fin_i,
  output logic [2:0] pop_o,
  output logic [2:0] closed_o,
  output logic       sym_valid_o,
  input  logic       sym_ready_i,
  output sym_t       sym_o,
  output logic       flush_o
);
  pass_e      dq_q;
  logic [2:0] closed_q, sel, clr;

  assign sel         = 3'b001 << dq_q;
  assign sym_valid_o = !empty_i[dq_q];
  assign pop_o       = (sym_valid_o && sym_ready_i) ? sel : 3'b000;
  assign clr         = (empty_i[dq_q] && closed_q[dq_q]) ? sel : 3'b000;
  assign closed_o    = closed_q;
  assign flush_o     = fin_i && (&empty_i) && (closed_q == '0);

  always_comb begin
    case (dq_q)
      PASS_SP: sym_o = head_sp_i;
      PASS_MR: sym_o = head_mr_i;
      default: sym_o = head_cu_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q     <= PASS_CU;
      closed_q <= '0;
    end else begin
      closed_q <= (closed_q | close_i) & ~clr;
      if (begin_i) dq_q <= PASS_CU;
      else if (clr != '0) begin
        case (dq_q)
          PASS_SP: dq_q <= PASS_MR;
          PASS_MR: dq_q <= PASS_CU;
          default: dq_q <= PASS_SP;
        endcase
      end
    end
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ready_i) |=> (sym_valid_o && $stable(sym_o)));
  a_r5_one_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o));
  a_r8_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !sym_valid_o);
  a_r8_flush_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

// File: rtl/bitplane_pass_sequencer.sv
module bitplane_pass_sequencer
  import bpps_pkg::*;
#(
  parameter int COLS    = 4,
  parameter int STRIPES = 2,
  parameter int MAG_W   = 4,
  parameter int QDEPTH  = 2,
  localparam int ADDR_W = $clog2(COLS * 4 * STRIPES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [MAG_W-1:0]  mem_rdata_i,
  output logic              sym_valid_o,
  input  logic              sym_ready_i,
  output logic [CTX_W-1:0]  sym_ctx_o,
  output logic              sym_bit_o,
  output logic              flush_o
);
  localparam int SW = $bits(sym_t);

  sym_t       gen_sym, out_sym;
  sym_t       heads [3];
  logic [2:0] push, pop, full, empty, close, closed;
  logic       begin_blk, fin;

  bpps_pass_gen #(.COLS(COLS), .STRIPES(STRIPES), .MAG_W(MAG_W)) gen_i (
    .clk_i, .rst_ni, .start_i,
    .addr_o(mem_addr_o), .rdata_i(mem_rdata_i),
    .closed_i(closed), .full_i(full), .push_o(push), .sym_o(gen_sym),
    .close_o(close), .begin_o(begin_blk), .fin_o(fin), .flush_i(flush_o)
  );

  for (genvar q = 0; q < 3; q++) begin : g_queue
    bpps_fifo #(.DEPTH(QDEPTH), .W(SW)) fifo_i (
      .clk_i, .rst_ni,
      .push_i(push[q]), .din_i(gen_sym),
      .pop_i(pop[q]), .dout_o(heads[q]),
      .full_o(full[q]), .empty_o(empty[q])
    );
  end

  bpps_drain drain_i (
    .clk_i, .rst_ni, .begin_i(begin_blk),
    .head_sp_i(heads[0]), .head_mr_i(heads[1]), .head_cu_i(heads[2]),
    .empty_i(empty), .close_i(close), .fin_i(fin),
    .pop_o(pop), .closed_o(closed),
    .sym_valid_o, .sym_ready_i, .sym_o(out_sym), .flush_o
  );

  assign sym_ctx_o = out_sym.ctx;
  assign sym_bit_o = out_sym.dbit;
endmodule

// File: tb/bitplane_pass_sequencer_tb_top.sv
module bitplane_pass_sequencer_tb_top;
  localparam int COLS = 4, STRIPES = 2, MAG_W = 4;
  localparam int ROWS = 4 * STRIPES, N = COLS * ROWS, ADDR_W = $clog2(N);

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, ready = 1'b1;
  logic [ADDR_W-1:0] addr;
  logic [MAG_W-1:0]  rdata;
  logic              valid, dbit, flush;
  logic [4:0]        ctx;

  always #5 clk = ~clk;

  bitplane_pass_sequencer #(.COLS(COLS), .STRIPES(STRIPES), .MAG_W(MAG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .mem_addr_o(addr), .mem_rdata_i(rdata),
    .sym_valid_o(valid), .sym_ready_i(ready),
    .sym_ctx_o(ctx), .sym_bit_o(dbit), .flush_o(flush)
  );

  logic [MAG_W-1:0] mem [N];
  always @(posedge clk) rdata <= mem[addr];

  int checks = 0, errors = 0;
  int nexp, topp, got, flushes, mode, cyc;
  int first_ctx;
  logic [4:0] e_ctx [1024];
  logic       e_bit [1024];
  logic run = 1'b0, prev_stall = 1'b0, prev_flush = 1'b0;
  logic [4:0] prev_ctx;
  logic       prev_bit;

  task automatic chk(input logic ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic build_expected();
    logic [MAG_W-1:0] acc;
    bit sg [N];
    bit vs [N];
    acc = '0;
    nexp = 0;
    topp = -1;
    for (int i = 0; i < N; i++) begin acc |= mem[i]; sg[i] = 0; vs[i] = 0; end
    for (int i = 0; i < MAG_W; i++) if (acc[i]) topp = i;
    for (int p = topp; p >= 0; p--) begin
      for (int q = (p == topp) ? 2 : 0; q < 3; q++) begin
        for (int k = 0; k < N; k++) begin
          int row, col, a, nb;
          bit b, em;
          row = (k / (4 * COLS)) * 4 + k % 4;
          col = (k / 4) % COLS;
          a   = row * COLS + col;
          nb  = 0;
          if (row > 0 && sg[a-COLS]) nb++;
          if (row < ROWS-1 && sg[a+COLS]) nb++;
          if (col > 0 && sg[a-1]) nb++;
          if (col < COLS-1 && sg[a+1]) nb++;
          b = mem[a][p];
          if (q == 0) em = !sg[a] && nb > 0;
          else if (q == 1) em = sg[a] && !vs[a];
          else em = !sg[a] && !vs[a];
          if (em) begin
            e_ctx[nexp] = 5'(q * 8 + nb);
            e_bit[nexp] = b;
            nexp++;
          end
          if (q == 0 && em) begin vs[a] = 1; if (b) sg[a] = 1; end
          if (q == 2) begin if (em && b) sg[a] = 1; vs[a] = 0; end
        end
      end
    end
  endtask

  function automatic logic ready_for(input int m, input int c);
    case (m)
      0: return 1'b1;
      1: return (c % 4) == 0;
      2: return (c % 16) >= 12;
      default: return (((c * 5) >> 1) % 3) != 0;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (run) begin
      if (prev_stall)
        chk(valid && ctx == prev_ctx && dbit == prev_bit, "R6 held symbol",
            {valid, ctx, dbit}, {1'b1, prev_ctx, prev_bit});
      ready = ready_for(mode, cyc);
      if (valid && ready) begin
        if (got == 0) first_ctx = ctx;
        if (got < nexp) begin
          chk(ctx == e_ctx[got], "R4 R5 R9 context label", ctx, e_ctx[got]);
          chk(dbit == e_bit[got], "R4 R5 R9 decision bit", dbit, e_bit[got]);
        end else chk(1'b0, "R7 extra symbol", got + 1, nexp);
        got++;
      end
      prev_stall = valid && !ready;
      prev_ctx   = ctx;
      prev_bit   = dbit;
      if (flush) begin
        flushes++;
        chk(got == nexp && !valid, "R8 flush after last symbol", got, nexp);
        chk(!prev_flush, "R8 flush single cycle", 1, 0);
      end
      prev_flush = flush;
    end
  end

  task automatic run_block(input int m);
    int waited;
    build_expected();
    mode = m;
    got = 0;
    flushes = 0;
    first_ctx = -1;
    prev_stall = 1'b0;
    prev_flush = 1'b0;
    @(negedge clk);
    run = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (flushes == 0 && waited < 20000) begin @(negedge clk); waited++; end
    if (flushes == 0) chk(1'b0, "R8 watchdog, no flush", got, nexp);
    repeat (6) @(negedge clk);
    run = 1'b0;
    ready = 1'b1;
    chk(got == nexp, "R7 symbol count", got, nexp);
    chk(got == N * (topp + 1), "R3 one code per coefficient per plane", got, N * (topp + 1));
    chk(flushes == 1, "R8 flush count", flushes, 1);
    if (nexp > 0) chk(first_ctx / 8 == 2, "R2 top plane cleanup first", first_ctx / 8, 2);
  endtask

  initial begin
    int lfsr;
    cyc = 0;
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!valid && !flush, "R1 reset outputs", {valid, flush}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!valid && !flush, "R1 idle after reset", {valid, flush}, 0);

    run_block(0);                                     // R8 all-zero block
    mem[5 * COLS + 2] = 4'd8;                         // isolated coefficient
    run_block(0);
    for (int i = 0; i < N; i++) mem[i] = 4'((i * 7 + 3) % 16);
    run_block(0);
    run_block(1);
    lfsr = 32'h1d;
    for (int i = 0; i < N; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 4) ^ (lfsr >> 2)) & 1)) & 32'h1f;
      mem[i] = 4'(lfsr);
    end
    run_block(2);
    for (int i = 0; i < N; i++) mem[i] = (i % 5 == 0) ? 4'd1 : 4'd0;  // top plane 0
    run_block(3);
    for (int i = 0; i < N; i++) mem[i] = 4'd15;
    run_block(2);
    for (int i = 0; i < N; i++) mem[i] = 4'(i % 3);
    run_block(1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule